// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small, fully associative store of recent page translations that sits inside an address translation unit. Each line holds one translation: a virtual page number used as the tag and the physical page number it maps to. A lookup presents a virtual page number and, one clock later, the block answers with a hit and the stored physical page number, or with a miss. On a hit the translated address can go straight to memory without a page-table access costing tens to hundreds of cycles. On a miss the surrounding logic walks the page table and then writes the result through the fill port.

A fill whose page number is already present rewrites that line in place. Otherwise the fill goes to the lowest-numbered empty line. When no line is empty, it displaces the line chosen by a rotating victim pointer. A flush input empties the whole store in one cycle.

Top module: `xlat_buffer`

## Requirements
- R1: After a synchronous active-low reset, rsp_valid, rsp_hit and rsp_ppn are 0 and every line is empty, so any lookup misses.
- R2: rsp_valid is high in exactly the cycle after a cycle in which lk_valid was high.
- R3: A lookup whose page number matches a filled line returns rsp_hit=1 and that line's physical page number on rsp_ppn, one cycle later.
- R4: A lookup that matches no filled line returns rsp_hit=0 and rsp_ppn=0.
- R5: A fill whose page number is not resident, while an empty line exists, writes the lowest-numbered empty line and leaves the victim pointer unchanged.
- R6: A fill whose page number is not resident, while all lines are full, replaces the line named by the victim pointer. The pointer starts at line 0 and then steps by one, wrapping after the last line.
- R7: A fill whose page number is already resident overwrites only that line's physical page number. No duplicate is created and the victim pointer does not move.
- R8: flush=1 empties every line in one cycle and returns the victim pointer to line 0. A fill in the same cycle is dropped.
- R9: A lookup and a fill or flush in the same cycle are answered from the contents held before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W (22) | Virtual page number to look up |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VPN_W (22) | Virtual page number of the written translation |
| fill_ppn | input | PPN_W (12) | Physical page number of the written translation |
| flush | input | 1 | Empty all lines |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | The looked-up page was resident |
| rsp_ppn | output | PPN_W (12) | Physical page number on a hit, else 0 |

## Verification
A corrupted line or a wrong valid bit appears at the ports on the first lookup of the affected page number: the answer one cycle later carries the wrong hit flag or the wrong page number. A victim pointer that is off by one stays hidden until the store is full. It shows only when a later lookup finds that the wrong resident page was displaced, which can take up to a full rotation of fills. Lowest-empty placement is likewise seen only through the eviction order after the store fills up. The reference model therefore tracks placement and the pointer, and every lookup is compared against it.

// File: rtl/xlat_pkg.sv
// Shared sizing defaults for the translation buffer.
// Assumes: page-number widths fit a single compare per line.
package xlat_pkg;
    localparam int XLAT_LINES_DEF = 8;
    localparam int XLAT_VPN_W_DEF = 22;
    localparam int XLAT_PPN_W_DEF = 12;
endpackage

// File: rtl/xlat_line.sv
// One buffer line: valid flag, page-number tag and physical page number.
// It compares its tag against the lookup and fill page numbers.
// Assumes: clear has priority over write; write is one-hot across lines.
module xlat_line #(
    parameter int VPN_W = 22,
    parameter int PPN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             valid,
    output logic [PPN_W-1:0] ppn,
    output logic             lk_match,
    output logic             fill_match
);
    logic [VPN_W-1:0] tag_q;

    // Line state: emptied by reset or clear, loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid <= 1'b0;
        end else if (wr_en) begin
            valid <= 1'b1;
        end
    end

    // Tag and payload: loaded on a write, kept otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            ppn   <= '0;
        end else if (wr_en && !clear) begin
            tag_q <= wr_vpn;
            ppn   <= wr_ppn;
        end
    end

    // Tag compares for the lookup path and the fill path.
    always_comb begin
        lk_match   = valid && (tag_q == lk_vpn);
        fill_match = valid && (tag_q == wr_vpn);
    end

    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !valid); // R8
endmodule

// File: rtl/xlat_victim.sv
// Selects the line a new translation goes to: the lowest empty line,
// else the line named by a round-robin pointer that then steps on.
// Assumes: fill_go is only raised for fills with no resident match.
module xlat_victim #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill_go,
    input  logic [LINES-1:0] valid_vec,
    output logic [LINES-1:0] sel
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    logic [IDX_W-1:0] ptr;
    logic [LINES-1:0] first_free;
    logic [LINES-1:0] ptr_oh;
    logic             have_free;

    // Find the lowest-numbered empty line.
    always_comb begin
        first_free = '0;
        have_free  = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (!valid_vec[i] && !have_free) begin
                first_free[i] = 1'b1;
                have_free     = 1'b1;
            end
        end
    end

    // Decode the pointer into a line select.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            ptr_oh[i] = (ptr == IDX_W'(i));
        end
    end

    // Choose the target line: an empty line first, otherwise the pointer.
    always_comb begin
        sel = have_free ? first_free : ptr_oh;
    end

    // Step the pointer on each eviction; flush sends it back to line 0.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr <= '0;
        end else if (fill_go && !have_free) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && !have_free && !flush) |=>
        (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1))); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && have_free && !flush) |=> $stable(ptr)); // R5
    AST_FLUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr == '0)); // R8
endmodule

// File: rtl/xlat_pick.sv
// Merges the per-line match flags and payloads into one hit and one page.
// Assumes: at most one line matches, so an OR of gated payloads is exact.
module xlat_pick #(
    parameter int LINES = 8,
    parameter int PPN_W = 12
) (
    input  logic [LINES-1:0]            match_vec,
    input  logic [LINES-1:0][PPN_W-1:0] ppn_arr,
    output logic                        any_hit,
    output logic [PPN_W-1:0]            hit_ppn
);
    // OR the payload of the matching line; zero when nothing matches.
    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < LINES; i++) begin
            hit_ppn = hit_ppn | (ppn_arr[i] & {PPN_W{match_vec[i]}});
        end
        any_hit = |match_vec;
    end
endmodule

// File: rtl/xlat_buffer.sv
// Fully associative translation buffer: registered lookup answer, fill port
// with in-place update, lowest-empty placement and round-robin eviction,
// and a one-cycle flush.
// Assumes: lookups read the contents held before the same cycle's writes.
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int LINES = XLAT_LINES_DEF,
    parameter int VPN_W = XLAT_VPN_W_DEF,
    parameter int PPN_W = XLAT_PPN_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn
);
    logic [LINES-1:0]            valid_vec;
    logic [LINES-1:0]            lk_hit_vec;
    logic [LINES-1:0]            fill_hit_vec;
    logic [LINES-1:0]            wr_vec;
    logic [LINES-1:0]            victim_sel;
    logic [LINES-1:0][PPN_W-1:0] ppn_arr;
    logic                        any_hit;
    logic [PPN_W-1:0]            hit_ppn;
    logic                        fill_resident;
    logic                        fill_go;

    // The line array: one instance per entry.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        xlat_line #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (flush),
            .wr_en      (wr_vec[g]),
            .wr_vpn     (fill_vpn),
            .wr_ppn     (fill_ppn),
            .lk_vpn     (lk_vpn),
            .valid      (valid_vec[g]),
            .ppn        (ppn_arr[g]),
            .lk_match   (lk_hit_vec[g]),
            .fill_match (fill_hit_vec[g])
        );
    end

    // Fill routing: a resident page rewrites its own line, else the victim.
    always_comb begin
        fill_resident = |fill_hit_vec;
        fill_go       = fill_en && !flush && !fill_resident;
        wr_vec        = (fill_en && !flush)
                      ? (fill_resident ? fill_hit_vec : victim_sel) : '0;
    end

    xlat_victim #(.LINES(LINES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .fill_go   (fill_go),
        .valid_vec (valid_vec),
        .sel       (victim_sel)
    );

    xlat_pick #(.LINES(LINES), .PPN_W(PPN_W)) u_pick (
        .match_vec (lk_hit_vec),
        .ppn_arr   (ppn_arr),
        .any_hit   (any_hit),
        .hit_ppn   (hit_ppn)
    );

    // Register the lookup answer one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && any_hit;
            rsp_ppn   <= (lk_valid && any_hit) ? hit_ppn : '0;
        end
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec)); // R7
    AST_FILL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec)); // R5
    AST_RSP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R2
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R2
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0)); // R4
    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_ppn == '0)); // R1
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0)); // R8
endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
    localparam int LINES = 8;
    localparam int VPN_W = 22;
    localparam int PPN_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             fill_en = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             flush = 1'b0;
    logic             rsp_valid;
    logic             rsp_hit;
    logic [PPN_W-1:0] rsp_ppn;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model.
    bit               m_valid [LINES];
    logic [VPN_W-1:0] m_vpn   [LINES];
    logic [PPN_W-1:0] m_ppn   [LINES];
    int               m_ptr;

    always #10 clk = ~clk;

    xlat_buffer u_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_ppn(rsp_ppn)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_find(input logic [VPN_W-1:0] v);
        for (int i = 0; i < LINES; i++)
            if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    // Model update for a fill (R5, R6, R7).
    function automatic void model_fill(input logic [VPN_W-1:0] v,
                                       input logic [PPN_W-1:0] p);
        int idx = model_find(v);
        if (idx < 0) begin
            for (int i = 0; i < LINES; i++)
                if (!m_valid[i] && idx < 0) idx = i;
        end
        if (idx < 0) begin
            idx = m_ptr;
            m_ptr = (m_ptr + 1) % LINES;
        end
        m_valid[idx] = 1'b1;
        m_vpn[idx]   = v;
        m_ppn[idx]   = p;
    endfunction

    function automatic void model_flush();
        for (int i = 0; i < LINES; i++) m_valid[i] = 1'b0;
        m_ptr = 0;
    endfunction

    // One cycle: drive at negedge, sample at the next negedge.
    task automatic cycle(input bit lk, input logic [VPN_W-1:0] lv,
                         input bit fe, input logic [VPN_W-1:0] fv,
                         input logic [PPN_W-1:0] fp, input bit fl,
                         input string req);
        int idx = model_find(lv);
        bit exp_hit = lk && (idx >= 0);
        logic [PPN_W-1:0] exp_ppn = exp_hit ? m_ppn[idx] : '0;
        lk_valid = lk; lk_vpn = lv; fill_en = fe; fill_vpn = fv;
        fill_ppn = fp; flush = fl;
        @(negedge clk);
        lk_valid = 1'b0; fill_en = 1'b0; flush = 1'b0;
        if (fl) model_flush();
        else if (fe) model_fill(fv, fp);
        check(rsp_valid == lk, {req, " R2 rsp_valid"}, 32'(rsp_valid), 32'(lk));
        if (lk) begin
            check(rsp_hit == exp_hit, {req, " hit"}, 32'(rsp_hit), 32'(exp_hit));
            check(rsp_ppn == exp_ppn, {req, " ppn"}, 32'(rsp_ppn), 32'(exp_ppn));
        end
    endtask

    task automatic look(input logic [VPN_W-1:0] v, input string req);
        cycle(1'b1, v, 1'b0, '0, '0, 1'b0, req);
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
        cycle(1'b0, '0, 1'b1, v, p, 1'b0, "fill");
    endtask

    initial begin
        void'($urandom(32'd5227));
        model_flush();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!rsp_valid && !rsp_hit && rsp_ppn == '0, "R1 reset outputs",
              {rsp_valid, rsp_hit, 18'd0, rsp_ppn}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        look(22'h0, "R1 empty after reset");
        look(22'h12345, "R4 miss");
        // R5/R3: fill all lines, then hit each
        for (int i = 0; i < LINES; i++) fill(22'h100 + 22'(i), 12'h0A0 + 12'(i));
        for (int i = 0; i < LINES; i++) look(22'h100 + 22'(i), "R3 hit");
        // R6: evictions go to line 0, then line 1
        fill(22'h200, 12'h111);
        look(22'h100, "R6 first eviction");
        look(22'h101, "R6 survivor");
        fill(22'h201, 12'h222);
        look(22'h101, "R6 second eviction");
        // R7: resident refill rewrites in place; pointer stays on line 2
        fill(22'h200, 12'h333);
        look(22'h200, "R7 in-place update");
        fill(22'h202, 12'h444);
        look(22'h102, "R7 pointer unchanged");
        look(22'h103, "R7 next line kept");
        // R9: same-cycle lookup and fill sees old contents
        cycle(1'b1, 22'h300, 1'b1, 22'h300, 12'h555, 1'b0, "R9 lookup+fill");
        look(22'h300, "R9 fill visible next");
        // R8: flush with a simultaneous fill and lookup
        cycle(1'b1, 22'h300, 1'b1, 22'h301, 12'h666, 1'b1, "R8 R9 flush");
        look(22'h300, "R8 flushed");
        look(22'h301, "R8 fill dropped");
        // R8/R5: pointer back to 0 and lowest-empty placement after flush
        for (int i = 0; i < LINES; i++) fill(22'h400 + 22'(i), 12'h700 + 12'(i));
        fill(22'h4FF, 12'h7FF);
        look(22'h400, "R8 R5 eviction restarts at line 0");
        look(22'h401, "R5 survivor");
        // Idle cycle: no answer
        cycle(1'b0, '0, 1'b0, '0, '0, 1'b0, "R2 idle");
        // Random mix against the model (R3 R4 R5 R6 R7 R9)
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            logic [VPN_W-1:0] lv = 22'h500 + 22'($urandom_range(0, 13));
            logic [VPN_W-1:0] fv = 22'h500 + 22'($urandom_range(0, 13));
            logic [PPN_W-1:0] fp = 12'($urandom);
            cycle(r < 70, lv, (r % 3) == 0, fv, fp, r == 99, "random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule